// File: doc/BRIEF.md
# Parallel TCAM Entry Error Scanner

This block holds a small ternary content-addressable array and searches it for corrupted entries in the background. Every stored information symbol sits beside a check copy of itself, so a healthy symbol pair is always one of 00, 11 or don't-care/don't-care. A pair that has been disturbed in one of its two symbols, including a change to or from don't-care, can be found with two ternary searches. One search key carries 0 then 1 at that pair. The other carries 1 then 0. Every other position of both keys is don't-care. A healthy pair matches both keys or neither. A damaged pair matches exactly one.

A scan is started by a one-cycle start pulse. The controller then applies one key per clock, two keys per pair position, to all entries at once. Each entry owns a one-bit toggle counter that flips whenever its match line is high. The counter is sampled and cleared at the end of each two-key group, and an odd count sets that entry's sticky error flag. The scan length therefore depends only on the word width and not on the number of entries. After the scan, a lowest-index-first priority encoder hands out the flagged entries one at a time. Each one is released by an acknowledge. When none remain, a one-cycle done pulse is given and the block returns to idle.

Writes come in through a normal port and are encoded into symbol pairs automatically. A separate fault port lets a test environment overwrite any single stored symbol code.

Top module: `tcam_err_scan`

State machine: `ST_IDLE` (waits; accepts writes) goes to `ST_SCAN` on start. `ST_SCAN` (one key per cycle) goes to `ST_REPORT` after its last key. `ST_REPORT` (hands out flags) goes to `ST_DONE` once no flag is left. `ST_DONE` lasts one cycle and goes back to `ST_IDLE`.

## Requirements
- R1: Symbol codes are 00 for 0, 01 for 1, 11 for don't-care and 10 for illegal. A stored don't-care or a key don't-care matches anything. A stored illegal code matches nothing. An entry matches a key only if all of its stored symbols match.
- R2: Information symbol j of `wr_data` sits at bits [2j+1:2j]. A write places it at stored symbol 2j and also at its check position 2j+1. Writes are taken only in the idle state.
- R3: A start pulse seen in idle clears every error flag. `busy` is then high from the next cycle until the report phase ends.
- R4: The scan applies 2*W keys, one per cycle. Keys 2p and 2p+1 test pair p with 01 and then 10, and every other symbol is don't-care. No report appears before the scan has finished.
- R5: Each entry's one-bit counter toggles on every key its match line accepts. At the end of each two-key group an odd counter sets that entry's sticky flag, and the counter returns to zero.
- R6: Entries whose pairs are all 00, 11 or don't-care/don't-care are never flagged. An entry with a pair that matches exactly one of its two keys is flagged.
- R7: An entry that holds an illegal code matches no key, so it is never flagged, even when it also holds a damaged pair.
- R8: In the report phase `err_valid` is high and `err_idx` gives the lowest flagged entry. An acknowledge clears that flag, and the next flagged entry is shown in the following cycle.
- R9: Once no flag is left, `done` is high for exactly one cycle and the block is idle after that. `done` and `err_valid` are never high together.
- R10: A write presented while not idle is dropped. It gives a one-cycle `wr_reject` in the cycle after it.
- R11: Damage in two different pairs of the same entry still flags that entry, because each group is judged on its own.
- R12: After reset, `busy`, `err_valid`, `done` and `wr_reject` are low and every stored symbol holds the code for 0.
- R13: A start pulse while busy has no effect: the scan or report under way carries on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| wr_en | input | 1 | write request |
| wr_idx | input | 3 | entry to write |
| wr_data | input | 8 | W information symbols, 2 bits each |
| inj_en | input | 1 | fault port: overwrite one stored symbol |
| inj_idx | input | 3 | fault port entry |
| inj_sym | input | 3 | fault port stored symbol position (0..2W-1) |
| inj_code | input | 2 | fault port symbol code |
| start | input | 1 | begin a scan (taken in idle only) |
| ack | input | 1 | release the reported entry |
| busy | output | 1 | scan or report under way |
| err_valid | output | 1 | a flagged entry is being reported |
| err_idx | output | 3 | lowest flagged entry |
| done | output | 1 | one-cycle end-of-report pulse |
| wr_reject | output | 1 | the previous cycle's write was dropped |

## Verification
The start edge makes `busy` visible one cycle later. With W=4 the first report, or its absence, is due 2*W+1 = 9 clock edges after the start edge. The next index appears one cycle after an acknowledge, `done` follows one cycle after the last flag is released, and `wr_reject` appears one cycle after a write that is dropped. The bench drives and samples 1 ns after each rising edge, counts edges exactly, and at every intermediate scan cycle confirms that no report has appeared yet. Each scan's report order is compared against a hand-derived mask of faulted entries, released lowest index first.

// File: rtl/tes_pkg.sv
package tes_pkg;

    localparam logic [1:0] SYM_ZERO = 2'b00;
    localparam logic [1:0] SYM_ONE  = 2'b01;
    localparam logic [1:0] SYM_BAD  = 2'b10;
    localparam logic [1:0] SYM_ANY  = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_REPORT,
        ST_DONE
    } scan_state_t;

    // one stored symbol against one key symbol
    function automatic logic sym_match(input logic [1:0] stored, input logic [1:0] key);
        logic m;
        if (stored == SYM_BAD)      m = 1'b0;
        else if (key == SYM_ANY)    m = 1'b1;
        else if (stored == SYM_ANY) m = 1'b1;
        else                        m = (stored == key);
        return m;
    endfunction

endpackage

// File: rtl/tes_key_gen.sv
module tes_key_gen
    import tes_pkg::*;
#(
    parameter int N_INFO = 4,
    localparam int SYMS  = 2 * N_INFO,
    localparam int STEPW = (SYMS > 1) ? $clog2(SYMS) : 1
) (
    input  logic [STEPW-1:0]  step,
    output logic [2*SYMS-1:0] key
);
    int unsigned pair_pos;
    logic        second;

    always_comb begin
        pair_pos = int'(step) >> 1;
        second   = step[0];
        for (int s = 0; s < SYMS; s++) begin
            if (s == 2 * pair_pos)
                key[2*s +: 2] = second ? SYM_ONE : SYM_ZERO;
            else if (s == 2 * pair_pos + 1)
                key[2*s +: 2] = second ? SYM_ZERO : SYM_ONE;
            else
                key[2*s +: 2] = SYM_ANY;
        end
    end

endmodule

// File: rtl/tes_store.sv
module tes_store
    import tes_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int N_INFO    = 4,
    localparam int SYMS     = 2 * N_INFO,
    localparam int ROWW     = 2 * SYMS,
    localparam int IDXW     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
    localparam int STEPW    = (SYMS > 1) ? $clog2(SYMS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_take,
    input  logic [IDXW-1:0]      wr_idx,
    input  logic [2*N_INFO-1:0]  wr_data,
    input  logic                 inj_en,
    input  logic [IDXW-1:0]      inj_idx,
    input  logic [STEPW-1:0]     inj_sym,
    input  logic [1:0]           inj_code,
    input  logic [ROWW-1:0]      key,
    output logic [N_ENTRIES-1:0] match_line
);
    logic [ROWW-1:0] rows [N_ENTRIES];
    logic [ROWW-1:0] enc_row;

    // each information symbol is followed by its check copy
    always_comb begin
        for (int j = 0; j < N_INFO; j++) begin
            enc_row[4*j +: 2]     = wr_data[2*j +: 2];
            enc_row[4*j + 2 +: 2] = wr_data[2*j +: 2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < N_ENTRIES; e++)
                rows[e] <= '0;
        end else begin
            if (wr_take)
                rows[wr_idx] <= enc_row;
            if (inj_en)
                rows[inj_idx][2*inj_sym +: 2] <= inj_code;
        end
    end

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_row
        always_comb begin
            match_line[e] = 1'b1;
            for (int s = 0; s < SYMS; s++)
                if (!sym_match(rows[e][2*s +: 2], key[2*s +: 2]))
                    match_line[e] = 1'b0;
        end
    end

endmodule

// File: rtl/tes_parity.sv
module tes_parity #(
    parameter int N_ENTRIES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_all,
    input  logic                 step_en,
    input  logic                 group_end,
    input  logic [N_ENTRIES-1:0] match_line,
    input  logic [N_ENTRIES-1:0] release_vec,
    output logic [N_ENTRIES-1:0] flags
);
    logic [N_ENTRIES-1:0] odd_cnt;

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cnt
        logic toggled;
        assign toggled = odd_cnt[e] ^ match_line[e];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                odd_cnt[e] <= 1'b0;
                flags[e]   <= 1'b0;
            end else if (clear_all) begin
                odd_cnt[e] <= 1'b0;
                flags[e]   <= 1'b0;
            end else if (step_en) begin
                if (group_end) begin
                    flags[e]   <= flags[e] | toggled;
                    odd_cnt[e] <= 1'b0;
                end else begin
                    odd_cnt[e] <= toggled;
                end
            end else if (release_vec[e]) begin
                flags[e] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tes_prienc.sv
module tes_prienc #(
    parameter int N_ENTRIES = 8,
    localparam int IDXW     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic [N_ENTRIES-1:0] req,
    output logic                 any,
    output logic [IDXW-1:0]      idx,
    output logic [N_ENTRIES-1:0] grant
);
    always_comb begin
        idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--)
            if (req[i]) idx = IDXW'(i);
    end

    assign any   = |req;
    assign grant = req & (~req + N_ENTRIES'(1));

endmodule

// File: rtl/tes_ctrl.sv
module tes_ctrl
    import tes_pkg::*;
#(
    parameter int N_INFO = 4,
    localparam int SYMS  = 2 * N_INFO,
    localparam int STEPW = (SYMS > 1) ? $clog2(SYMS) : 1,
    localparam logic [STEPW-1:0] LAST_STEP = STEPW'(SYMS - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ack,
    input  logic             wr_en,
    input  logic             any_flag,
    output scan_state_t      state,
    output logic [STEPW-1:0] step,
    output logic             step_en,
    output logic             group_end,
    output logic             clear_all,
    output logic             take_ack,
    output logic             wr_take,
    output logic             busy,
    output logic             done,
    output logic             err_valid,
    output logic             wr_reject
);
    scan_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_SCAN;
            ST_SCAN:   if (step == LAST_STEP) nxt = ST_REPORT;
            ST_REPORT: if (!any_flag) nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        step_en   = 1'b0;
        clear_all = 1'b0;
        err_valid = 1'b0;
        wr_take   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                clear_all = start;
                wr_take   = wr_en;
            end
            ST_SCAN: begin
                busy    = 1'b1;
                step_en = 1'b1;
            end
            ST_REPORT: begin
                busy      = 1'b1;
                err_valid = any_flag;
            end
            ST_DONE: done = 1'b1;
        endcase
        group_end = step[0];
        take_ack  = err_valid & ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step      <= '0;
            wr_reject <= 1'b0;
        end else begin
            wr_reject <= wr_en & (state != ST_IDLE);
            if (clear_all)    step <= '0;
            else if (step_en) step <= step + STEPW'(1);
        end
    end

endmodule

// File: rtl/tcam_err_scan.sv
module tcam_err_scan
    import tes_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int N_INFO    = 4,
    localparam int SYMS     = 2 * N_INFO,
    localparam int IDXW     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
    localparam int STEPW    = (SYMS > 1) ? $clog2(SYMS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDXW-1:0]     wr_idx,
    input  logic [2*N_INFO-1:0] wr_data,
    input  logic                inj_en,
    input  logic [IDXW-1:0]     inj_idx,
    input  logic [STEPW-1:0]    inj_sym,
    input  logic [1:0]          inj_code,
    input  logic                start,
    input  logic                ack,
    output logic                busy,
    output logic                err_valid,
    output logic [IDXW-1:0]     err_idx,
    output logic                done,
    output logic                wr_reject
);
    scan_state_t          state;
    logic [STEPW-1:0]     step;
    logic                 step_en, group_end, clear_all, take_ack, wr_take;
    logic                 any_flag;
    logic [2*SYMS-1:0]    key;
    logic [N_ENTRIES-1:0] match_line, flags, grant, release_vec;

    tes_ctrl #(.N_INFO(N_INFO)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .ack(ack), .wr_en(wr_en),
        .any_flag(any_flag), .state(state), .step(step), .step_en(step_en),
        .group_end(group_end), .clear_all(clear_all), .take_ack(take_ack),
        .wr_take(wr_take), .busy(busy), .done(done), .err_valid(err_valid),
        .wr_reject(wr_reject)
    );

    tes_key_gen #(.N_INFO(N_INFO)) u_key (
        .step(step), .key(key)
    );

    tes_store #(.N_ENTRIES(N_ENTRIES), .N_INFO(N_INFO)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_take(wr_take), .wr_idx(wr_idx),
        .wr_data(wr_data), .inj_en(inj_en), .inj_idx(inj_idx),
        .inj_sym(inj_sym), .inj_code(inj_code), .key(key),
        .match_line(match_line)
    );

    assign release_vec = grant & {N_ENTRIES{take_ack}};

    tes_parity #(.N_ENTRIES(N_ENTRIES)) u_parity (
        .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .step_en(step_en),
        .group_end(group_end), .match_line(match_line),
        .release_vec(release_vec), .flags(flags)
    );

    tes_prienc #(.N_ENTRIES(N_ENTRIES)) u_prienc (
        .req(flags), .any(any_flag), .idx(err_idx), .grant(grant)
    );

endmodule

// File: rtl/tcam_err_scan_chk.sv
module tcam_err_scan_chk #(
    parameter int N_ENTRIES = 8,
    parameter int N_INFO    = 4,
    localparam int IDXW     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
    localparam int CNTW     = $clog2(2 * N_INFO + 2) + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            ack,
    input logic            wr_en,
    input logic            busy,
    input logic            err_valid,
    input logic [IDXW-1:0] err_idx,
    input logic            done,
    input logic            wr_reject
);
    localparam logic [CNTW-1:0] SCAN_LEN = CNTW'(2 * N_INFO);
    logic [CNTW-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     busy_cnt <= '0;
        else if (!busy)                 busy_cnt <= '0;
        else if (busy_cnt != {CNTW{1'b1}}) busy_cnt <= busy_cnt + CNTW'(1);
    end

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);

    // R4
    scan_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (busy_cnt >= SCAN_LEN));

    // R8
    valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> busy);

    // R8
    ack_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && ack) |=> !(err_valid && err_idx == $past(err_idx)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9
    valid_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_valid && done));

    // R10
    reject_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (busy || done)) |=> wr_reject);

    // R10
    reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> $past(wr_en));

endmodule

bind tcam_err_scan tcam_err_scan_chk #(.N_ENTRIES(N_ENTRIES), .N_INFO(N_INFO)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .ack(ack), .wr_en(wr_en),
    .busy(busy), .err_valid(err_valid), .err_idx(err_idx), .done(done),
    .wr_reject(wr_reject)
);

// File: tb/tcam_err_scan_tb.sv
module tcam_err_scan_tb;
    localparam int N = 8;
    localparam int W = 4;
    localparam logic [7:0] PAT_P = 8'hC4; // symbols 0,1,0,* (j=0 first)
    localparam logic [7:0] PAT_Q = 8'hDD; // symbols 1,*,1,*

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, inj_en = 1'b0, start = 1'b0, ack = 1'b0;
    logic [2:0] wr_idx = '0, inj_idx = '0, inj_sym = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] inj_code = '0;
    logic       busy, err_valid, done, wr_reject;
    logic [2:0] err_idx;

    int n_total = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    tcam_err_scan u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .inj_en(inj_en), .inj_idx(inj_idx),
        .inj_sym(inj_sym), .inj_code(inj_code), .start(start), .ack(ack),
        .busy(busy), .err_valid(err_valid), .err_idx(err_idx), .done(done),
        .wr_reject(wr_reject)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat_of(input int e);
        return (e % 2 == 0) ? PAT_P : PAT_Q;
    endfunction

    task automatic write_entry(input int e, input logic [7:0] d);
        wr_en = 1'b1; wr_idx = 3'(e); wr_data = d;
        tick();
        wr_en = 1'b0;
        chk(wr_reject == 1'b0, "R2", "idle write not rejected", int'(wr_reject), 0);
    endtask

    task automatic inject(input int e, input int s, input logic [1:0] code);
        inj_en = 1'b1; inj_idx = 3'(e); inj_sym = 3'(s); inj_code = code;
        tick();
        inj_en = 1'b0;
    endtask

    // entered with the block in ST_REPORT
    task automatic report_phase(input logic [N-1:0] exp, input string req);
        logic [N-1:0] pending = exp;
        int guard = 0;
        while (pending != '0 && guard < N + 2) begin
            int lo = 0;
            for (int i = N - 1; i >= 0; i--) if (pending[i]) lo = i;
            chk(err_valid == 1'b1, req, "R8 err_valid", int'(err_valid), 1);
            chk(int'(err_idx) == lo, req, "R8 err_idx lowest", int'(err_idx), lo);
            ack = 1'b1;
            tick();
            ack = 1'b0;
            pending[lo] = 1'b0;
            guard++;
        end
        chk(err_valid == 1'b0 && busy == 1'b1, req, "R9 no flag left",
            int'({err_valid, busy}), 1);
        tick();
        chk(done == 1'b1 && busy == 1'b0, req, "R9 done pulse", int'({done, busy}), 2);
        tick();
        chk(done == 1'b0 && busy == 1'b0, req, "R9 back to idle", int'({done, busy}), 0);
    endtask

    task automatic start_and_wait(input string req);
        start = 1'b1;
        tick();
        start = 1'b0;
        chk(busy == 1'b1, "R3", "busy after start", int'(busy), 1);
        for (int c = 1; c < 2 * W; c++) begin
            chk(busy && !err_valid && !done, "R4", "quiet during scan",
                int'({busy, err_valid, done}), 4);
            tick();
        end
        tick();
        chk(busy == 1'b1, req, "R4 in report after 2W keys", int'(busy), 1);
    endtask

    task automatic run_scan(input logic [N-1:0] exp, input string req);
        start_and_wait(req);
        report_phase(exp, req);
    endtask

    task automatic t_reset();
        chk(!busy && !err_valid && !done && !wr_reject, "R12", "reset outputs",
            int'({busy, err_valid, done, wr_reject}), 0);
        run_scan('0, "R12");
    endtask

    task automatic t_healthy();
        for (int e = 0; e < N; e++) write_entry(e, pat_of(e));
        run_scan('0, "R6");
    endtask

    task automatic t_single_faults();
        inject(2, 1, 2'b11); // pair0 (0,*)
        inject(5, 4, 2'b00); // pair2 (0,1)
        inject(7, 7, 2'b00); // pair3 (*,0)
        run_scan(8'hA4, "R5 R1");
    endtask

    task automatic t_start_ignored();
        start_and_wait("R13");
        chk(err_valid && err_idx == 3'd2, "R13", "first report", int'(err_idx), 2);
        start = 1'b1;
        tick();
        start = 1'b0;
        chk(err_valid && err_idx == 3'd2 && busy, "R13", "start ignored",
            int'(err_idx), 2);
        report_phase(8'hA4, "R13");
    endtask

    task automatic t_repair();
        write_entry(2, PAT_P);
        write_entry(5, PAT_Q);
        write_entry(7, PAT_Q);
        run_scan('0, "R3 R2");
    endtask

    task automatic t_two_pairs();
        inject(1, 1, 2'b00); // pair0 (1,0)
        inject(1, 3, 2'b01); // pair1 (*,1)
        run_scan(8'h02, "R11");
        write_entry(1, PAT_Q);
    endtask

    task automatic t_illegal();
        inject(6, 0, 2'b10);
        inject(6, 3, 2'b00);
        inject(3, 2, 2'b10);
        inject(0, 1, 2'b11);
        run_scan(8'h01, "R7");
        write_entry(0, PAT_P);
        write_entry(3, PAT_Q);
        write_entry(6, PAT_P);
    endtask

    task automatic t_reject();
        inject(4, 7, 2'b00); // pair3 (*,0)
        start = 1'b1;
        tick();
        start = 1'b0;
        wr_en = 1'b1; wr_idx = 3'd4; wr_data = PAT_P;
        tick();
        wr_en = 1'b0;
        chk(wr_reject == 1'b1, "R10", "reject pulse", int'(wr_reject), 1);
        tick();
        chk(wr_reject == 1'b0, "R10", "reject one cycle", int'(wr_reject), 0);
        repeat (2 * W - 2) tick();
        report_phase(8'h10, "R10");
        write_entry(4, PAT_P);
    endtask

    task automatic t_all_entries();
        for (int e = 0; e < N; e++) inject(e, 0, 2'b11);
        run_scan(8'hFF, "R8 R1");
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_healthy();
        t_single_faults();
        t_start_ignored();
        t_repair();
        t_two_pairs();
        t_illegal();
        t_reject();
        t_all_entries();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule